// File: doc/BRIEF.md
# Slave-Serial Bitstream Loader

This block runs the whole configuration sequence for an FPGA that takes its bitstream one bit at a time on a clock and data pin pair. After a start request it holds the program pin low for a fixed number of cycles and then releases it. It then waits a bounded number of cycles for the target's init pin to rise. Next it shifts each incoming byte out MSB first, and after the last byte it keeps clocking until the target's done pin goes high. A timeout in either wait ends the load with a coded error.

Bitstream bytes arrive on a valid/ready stream that marks the final byte with a last flag. An optional swap mode sends each 4-byte group in reversed order, so byte k goes out at position k XOR 3. This lets an image stored as little-endian 32-bit words be replayed in the order the target expects. The swap mode accepts only images made of whole words.

Top module: `bitload_master`

## Requirements
- R1: Out of reset the block is idle: `cfg_prog_n`=1, `cfg_clk`=0, `cfg_dout`=0, `busy`=0, `load_ok`=0, `load_err`=0, `s_ready`=0.
- R2: A start request taken while not busy raises `busy` and drives `cfg_prog_n` low for exactly HOLD_CYC cycles, after which it stays high until the next start.
- R3: If `cfg_init` stays low for INIT_POLLS cycles after release, the load ends with `load_err`=1 and `err_code`=1, and no clock pulse is produced.
- R4: Each bit is put on `cfg_dout` before its clock rises, `cfg_clk` stays high for exactly HALF_CYC cycles, and `cfg_dout` does not change while `cfg_clk` is high.
- R5: With `swap_en`=0 the bytes leave in arrival order, each MSB first.
- R6: With `swap_en`=1 the byte at stream index k leaves at position k XOR 3 (order 3,2,1,0,7,6,5,4,...).
- R7: With `swap_en`=1, a last byte that does not close a 4-byte group ends the load with `err_code`=3 once all complete groups have been shifted out. The partial group is never shifted.
- R8: After the last data bit, single clock pulses (with `cfg_dout`=1) continue while `cfg_done` is low. `load_ok` rises only after `cfg_done` has been sampled high, and no further pulse follows.
- R9: If `cfg_done` is still low after DONE_PULSES trailing pulses, the load ends with `load_err`=1 and `err_code`=2, with exactly DONE_PULSES trailing pulses produced.
- R10: `load_ok`, `load_err` and `err_code` hold until the next start request, which clears them. Error codes: 0 none, 1 init timeout, 2 done timeout, 3 misaligned swap image.
- R11: `s_ready` stays low except while the data phase is active, so no byte is taken before `cfg_init` has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load; ignored while busy |
| swap_en | input | 1 | Reverse bytes within 4-byte groups; sampled with start |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DW | Stream byte |
| s_last | input | 1 | Marks the final stream byte |
| s_ready | output | 1 | Stream byte accepted this cycle when high with s_valid |
| cfg_prog_n | output | 1 | Target program pin, active low |
| cfg_clk | output | 1 | Target configuration clock |
| cfg_dout | output | 1 | Target configuration data |
| cfg_init | input | 1 | Target init pin (pulled up) |
| cfg_done | input | 1 | Target done pin (pulled up) |
| busy | output | 1 | Load in progress |
| load_ok | output | 1 | Last load finished with done seen high |
| load_err | output | 1 | Last load ended with an error |
| err_code | output | 2 | Error cause, encoding in R10 |

## Verification
The properties assume that `cfg_done` and `cfg_init` are ordinary level inputs that may be high at any time, and that the stream keeps `s_data` and `s_last` steady while `s_valid` waits for `s_ready`. The bench keeps to this by changing stream inputs only at falling clock edges after a handshake has been seen. It also drives `cfg_done` from a model that counts trailing clock rises, so the target's response follows the clock the block produces. The bench never pulses start during a load, because the block ignores start while busy.

// File: rtl/bitload_pkg.sv
// Shared types for the slave-serial bitstream loader.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package bitload_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_DATA,
        ST_DRAIN,
        ST_TRAIL,
        ST_OK,
        ST_FAIL
    } ctrl_state_t;

    typedef enum logic [1:0] {
        FAIL_NONE  = 2'd0,
        FAIL_INIT  = 2'd1,
        FAIL_DONE  = 2'd2,
        FAIL_ALIGN = 2'd3
    } fail_code_t;

    localparam int unsigned GROUP_BYTES = 4;

endpackage

// File: rtl/bitload_reorder.sv
// Byte grouper: collects one byte (plain mode) or GROUP_BYTES bytes (swap
// mode) and replays the group last-first. Flags a last byte that does not
// close a group in swap mode; that partial group is dropped.
// Assumes: o_ready only while the consumer can take a byte; flush clears.
module bitload_reorder
    import bitload_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          en,
    input  logic          swap,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic          o_valid,
    output logic [DW-1:0] o_data,
    output logic          o_last,
    input  logic          o_ready,
    output logic          align_err
);
    localparam int unsigned FW = $clog2(GROUP_BYTES + 1);
    localparam int unsigned RW = $clog2(GROUP_BYTES);

    logic [DW-1:0] hold_q [GROUP_BYTES];
    logic [FW-1:0] fill_q;
    logic [RW-1:0] rd_q;
    logic          drain_q;
    logic          last_q;
    logic [FW-1:0] grp;
    logic [FW-1:0] grp_m1;
    logic [FW-1:0] fill_next;
    logic          accept;

    // Group size and handshake terms.
    always_comb begin
        grp       = swap ? FW'(GROUP_BYTES) : FW'(1);
        grp_m1    = grp - FW'(1);
        fill_next = fill_q + FW'(1);
        s_ready   = en && !drain_q;
        accept    = s_valid && s_ready;
        align_err = accept && s_last && (fill_next != grp);
        o_valid   = drain_q;
        o_data    = hold_q[rd_q];
        o_last    = last_q && (rd_q == '0);
    end

    // Fill a group, then replay it from its highest index down.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < GROUP_BYTES; i++) hold_q[i] <= '0;
            fill_q  <= '0;
            rd_q    <= '0;
            drain_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            if (accept) begin
                hold_q[fill_q[RW-1:0]] <= s_data;
                if (fill_next == grp) begin
                    fill_q  <= '0;
                    drain_q <= 1'b1;
                    rd_q    <= grp_m1[RW-1:0];
                    last_q  <= s_last;
                end else if (s_last) begin
                    fill_q <= '0;
                end else begin
                    fill_q <= fill_next;
                end
            end
            if (o_valid && o_ready) begin
                if (rd_q == '0) drain_q <= 1'b0;
                else            rd_q    <= rd_q - RW'(1);
            end
        end
    end

endmodule

// File: rtl/bitload_serializer.sv
// Bit shifter: on go, sends go_nbits bits of go_data MSB first. Each bit is
// HALF_CYC cycles with the clock low (data set up) then HALF_CYC cycles high.
// Assumes: go is only raised while ready is high.
module bitload_serializer #(
    parameter int unsigned DW       = 8,
    parameter int unsigned HALF_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic [DW-1:0]            go_data,
    input  logic [$clog2(DW+1)-1:0]  go_nbits,
    output logic                     ready,
    output logic                     sclk,
    output logic                     sdat
);
    localparam int unsigned BW = $clog2(DW + 1);
    localparam int unsigned TW = $clog2(HALF_CYC + 1);
    localparam logic [TW-1:0] HALF_LAST = TW'(HALF_CYC - 1);

    typedef enum logic [1:0] {SER_IDLE, SER_LOW, SER_HIGH} ser_state_t;

    ser_state_t     st_q;
    logic [DW-1:0]  sh_q;
    logic [BW-1:0]  left_q;
    logic [TW-1:0]  tmr_q;
    logic           dat_q;

    // Port view of the phase register.
    always_comb begin
        ready = (st_q == SER_IDLE);
        sclk  = (st_q == SER_HIGH);
        sdat  = dat_q;
    end

    // Phase timer and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SER_IDLE;
            sh_q   <= '0;
            left_q <= '0;
            tmr_q  <= '0;
            dat_q  <= 1'b0;
        end else begin
            case (st_q)
                SER_IDLE: if (go) begin
                    dat_q  <= go_data[DW-1];
                    sh_q   <= go_data << 1;
                    left_q <= go_nbits;
                    tmr_q  <= '0;
                    st_q   <= SER_LOW;
                end
                SER_LOW: begin
                    if (tmr_q == HALF_LAST) begin
                        tmr_q <= '0;
                        st_q  <= SER_HIGH;
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                SER_HIGH: begin
                    if (tmr_q == HALF_LAST) begin
                        tmr_q <= '0;
                        if (left_q == BW'(1)) begin
                            st_q <= SER_IDLE;
                        end else begin
                            dat_q  <= sh_q[DW-1];
                            sh_q   <= sh_q << 1;
                            left_q <= left_q - BW'(1);
                            st_q   <= SER_LOW;
                        end
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                default: st_q <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bitload_seq.sv
// Load sequencer: program pulse, bounded init wait, data phase, drain,
// trailing clocks until done, and terminal ok/fail states.
// Assumes: ser_ready reflects the shifter one cycle after a go.
module bitload_seq
    import bitload_pkg::*;
#(
    parameter int unsigned HOLD_CYC    = 1200,
    parameter int unsigned INIT_POLLS  = 100000,
    parameter int unsigned DONE_PULSES = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       swap_in,
    input  logic       init_in,
    input  logic       done_in,
    input  logic       last_fire,
    input  logic       align_err,
    input  logic       ser_ready,
    output logic       prog_n,
    output logic       data_phase,
    output logic       swap_q,
    output logic       flush,
    output logic       pulse_go,
    output logic       busy,
    output logic       ok,
    output logic       err,
    output logic [1:0] code
);
    localparam int unsigned MAX_AB = (HOLD_CYC > INIT_POLLS) ? HOLD_CYC : INIT_POLLS;
    localparam int unsigned MAX_C  = (MAX_AB > DONE_PULSES) ? MAX_AB : DONE_PULSES;
    localparam int unsigned CW     = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] HOLD_END  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] INIT_END  = CW'(INIT_POLLS - 1);
    localparam logic [CW-1:0] PULSE_END = CW'(DONE_PULSES);

    ctrl_state_t   st_q;
    logic [CW-1:0] cnt_q;
    fail_code_t    code_q;
    logic          idle_like;

    // Decoded outputs of the state register.
    always_comb begin
        idle_like  = (st_q == ST_IDLE) || (st_q == ST_OK) || (st_q == ST_FAIL);
        flush      = start && idle_like;
        prog_n     = (st_q != ST_PROG);
        data_phase = (st_q == ST_DATA);
        busy       = !idle_like;
        ok         = (st_q == ST_OK);
        err        = (st_q == ST_FAIL);
        code       = code_q;
        pulse_go   = (st_q == ST_TRAIL) && ser_ready && !done_in && (cnt_q != PULSE_END);
    end

    // Sequence state, shared wait counter and error cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            code_q <= FAIL_NONE;
            swap_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE, ST_OK, ST_FAIL: if (start) begin
                    st_q   <= ST_PROG;
                    cnt_q  <= '0;
                    code_q <= FAIL_NONE;
                    swap_q <= swap_in;
                end
                ST_PROG: begin
                    if (cnt_q == HOLD_END) begin
                        cnt_q <= '0;
                        st_q  <= ST_WAIT_INIT;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_WAIT_INIT: begin
                    if (init_in) begin
                        st_q <= ST_DATA;
                    end else if (cnt_q == INIT_END) begin
                        st_q   <= ST_FAIL;
                        code_q <= FAIL_INIT;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_DATA: begin
                    if (align_err) begin
                        code_q <= FAIL_ALIGN;
                        st_q   <= ST_DRAIN;
                    end else if (last_fire) begin
                        st_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: if (ser_ready) begin
                    cnt_q <= '0;
                    st_q  <= (code_q != FAIL_NONE) ? ST_FAIL : ST_TRAIL;
                end
                ST_TRAIL: if (ser_ready) begin
                    if (done_in) begin
                        st_q <= ST_OK;
                    end else if (cnt_q == PULSE_END) begin
                        st_q   <= ST_FAIL;
                        code_q <= FAIL_DONE;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bitload_master.sv
// Top of the slave-serial bitstream loader: joins the sequencer, the byte
// grouper and the bit shifter, and muxes data bytes and trailing pulses.
// Assumes: the stream holds data and last steady while valid waits.
module bitload_master #(
    parameter int unsigned DW          = 8,
    parameter int unsigned HOLD_CYC    = 1200,
    parameter int unsigned HALF_CYC    = 3,
    parameter int unsigned INIT_POLLS  = 100000,
    parameter int unsigned DONE_PULSES = 100000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          swap_en,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic          cfg_prog_n,
    output logic          cfg_clk,
    output logic          cfg_dout,
    input  logic          cfg_init,
    input  logic          cfg_done,
    output logic          busy,
    output logic          load_ok,
    output logic          load_err,
    output logic [1:0]    err_code
);
    localparam int unsigned BW = $clog2(DW + 1);

    logic          ro_valid, ro_last, ro_ready, align_err;
    logic [DW-1:0] ro_data, ser_data;
    logic [BW-1:0] ser_nbits;
    logic          ser_ready, ser_go, data_phase, flush, pulse_go, swap_q, last_fire;

    // Route either a data byte or a single trailing pulse to the shifter.
    always_comb begin
        ro_ready  = data_phase && ser_ready;
        last_fire = ro_valid && ro_ready && ro_last;
        ser_go    = pulse_go || (data_phase && ro_valid);
        ser_data  = data_phase ? ro_data : '1;
        ser_nbits = data_phase ? BW'(DW) : BW'(1);
    end

    bitload_seq #(
        .HOLD_CYC   (HOLD_CYC),
        .INIT_POLLS (INIT_POLLS),
        .DONE_PULSES(DONE_PULSES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .swap_in   (swap_en),
        .init_in   (cfg_init),
        .done_in   (cfg_done),
        .last_fire (last_fire),
        .align_err (align_err),
        .ser_ready (ser_ready),
        .prog_n    (cfg_prog_n),
        .data_phase(data_phase),
        .swap_q    (swap_q),
        .flush     (flush),
        .pulse_go  (pulse_go),
        .busy      (busy),
        .ok        (load_ok),
        .err       (load_err),
        .code      (err_code)
    );

    bitload_reorder #(.DW(DW)) u_reorder (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .en       (data_phase),
        .swap     (swap_q),
        .s_valid  (s_valid),
        .s_data   (s_data),
        .s_last   (s_last),
        .s_ready  (s_ready),
        .o_valid  (ro_valid),
        .o_data   (ro_data),
        .o_last   (ro_last),
        .o_ready  (ro_ready),
        .align_err(align_err)
    );

    bitload_serializer #(.DW(DW), .HALF_CYC(HALF_CYC)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (ser_go),
        .go_data (ser_data),
        .go_nbits(ser_nbits),
        .ready   (ser_ready),
        .sclk    (cfg_clk),
        .sdat    (cfg_dout)
    );

endmodule

// File: rtl/bitload_master_chk.sv
// Port-level properties of the loader, bound into every instance.
// Assumes: synchronous active-low reset on rst_n.
module bitload_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s_ready,
    input logic       cfg_prog_n,
    input logic       cfg_clk,
    input logic       cfg_dout,
    input logic       cfg_done,
    input logic       busy,
    input logic       load_ok,
    input logic       load_err
);
    // R1: pins rest when no load runs.
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cfg_prog_n && !cfg_clk));

    // R2: program pulse only inside a load.
    a_r2_prog_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n |-> busy);

    // R4: data steady while the configuration clock is high.
    a_r4_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dout));

    // R4: no clock while the target is held in program.
    a_r4_no_clk_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> cfg_prog_n);

    // R8: success follows a sampled done.
    a_r8_ok_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_ok) |-> $past(cfg_done));

    // R10: status outputs are mutually exclusive.
    a_r10_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, load_ok, load_err}));

    // R11: bytes taken only after program release, during a load.
    a_r11_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (busy && cfg_prog_n));
endmodule

bind bitload_master bitload_master_chk u_chk (.*);

// File: tb/bitload_master_bench.sv
// Scoreboard bench: run_load pushes the expected byte order into exp_q; the
// monitor rebuilds bytes from cfg_dout at each cfg_clk rise and compares.
module bitload_master_bench;
    localparam int HOLD  = 5;
    localparam int HALF  = 2;
    localparam int IPOLL = 50;
    localparam int DPUL  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, swap_en = 1'b0;
    logic       s_valid = 1'b0, s_last = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_ready, cfg_prog_n, cfg_clk, cfg_dout;
    logic       cfg_init = 1'b0, cfg_done = 1'b0;
    logic       busy, load_ok, load_err;
    logic [1:0] err_code;

    int checks = 0, errors = 0;
    int prog_low = 0, edges = 0, trail = 0, nb = 0, hi_run = 0, done_after = -1;
    logic [7:0] acc = 8'h00;
    logic       clk_prev = 1'b0, din_rise = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] stim [0:7];
    int         stim_n = 0;
    string      cur_tag = "R5";

    always #5 clk = ~clk;

    bitload_master #(
        .DW(8), .HOLD_CYC(HOLD), .HALF_CYC(HALF),
        .INIT_POLLS(IPOLL), .DONE_PULSES(DPUL)
    ) u_bitload_master (
        .clk(clk), .rst_n(rst_n), .start(start), .swap_en(swap_en),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .cfg_prog_n(cfg_prog_n), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout),
        .cfg_init(cfg_init), .cfg_done(cfg_done),
        .busy(busy), .load_ok(load_ok), .load_err(load_err), .err_code(err_code)
    );

    task automatic chk(input bit good, input string tag, input int act, input int expv);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: counts pins, rebuilds bytes, models the target's done pin.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cfg_prog_n) prog_low++;
            if (cfg_clk && !clk_prev) begin
                edges++;
                din_rise = cfg_dout;
                hi_run   = 1;
                if (exp_q.size() > 0) begin
                    acc = {acc[6:0], cfg_dout};
                    nb++;
                    if (nb == 8) begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(acc == e, cur_tag, int'(acc), int'(e));
                        nb = 0;
                    end
                end else begin
                    trail++;
                end
            end else if (cfg_clk) begin
                hi_run++;
                if (cfg_dout != din_rise) chk(1'b0, "R4", int'(cfg_dout), int'(din_rise));
            end
            if (!cfg_clk && clk_prev) chk(hi_run == HALF, "R4", hi_run, HALF);
            clk_prev = cfg_clk;
            cfg_done = (done_after >= 0) && (trail >= done_after);
        end
    end

    task automatic run_load(input bit swp, input int init_delay, input int dn_after, input string tag);
        int full;
        bit saw;
        cur_tag = tag;
        done_after = dn_after;
        cfg_init = 1'b0;
        prog_low = 0; edges = 0; trail = 0; nb = 0;
        exp_q.delete();
        full = swp ? (stim_n / 4) * 4 : stim_n;
        for (int i = 0; i < full; i++) exp_q.push_back(swp ? stim[i ^ 3] : stim[i]);
        @(negedge clk);
        start = 1'b1; swap_en = swp;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !load_err && !load_ok, "R10", int'({busy, load_ok, load_err}), 4);
        chk(!cfg_prog_n, "R2", int'(cfg_prog_n), 0);
        s_valid = 1'b1; s_data = stim[0]; s_last = (stim_n == 1);
        while (!cfg_prog_n) @(negedge clk);
        chk(prog_low == HOLD, "R2", prog_low, HOLD);
        saw = 1'b0;
        if (init_delay < 0) begin
            while (busy) begin
                if (s_ready) saw = 1'b1;
                @(negedge clk);
            end
        end else begin
            repeat (init_delay) begin
                if (s_ready) saw = 1'b1;
                @(negedge clk);
            end
            cfg_init = 1'b1;
        end
        chk(!saw, "R11", int'(saw), 0);
        if (init_delay >= 0) begin
            for (int i = 0; i < stim_n; i++) begin
                s_valid = 1'b1; s_data = stim[i]; s_last = (i == stim_n - 1);
                while (!s_ready) @(negedge clk);
                @(negedge clk);
                if (!busy) break;
            end
        end
        s_valid = 1'b0; s_last = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset.
        chk(cfg_prog_n && !cfg_clk && !cfg_dout, "R1", int'({cfg_prog_n, cfg_clk, cfg_dout}), 4);
        chk(!busy && !load_ok && !load_err && !s_ready, "R1",
            int'({busy, load_ok, load_err, s_ready}), 0);

        // R5 and R8: plain order, done after three trailing pulses.
        stim[0] = 8'hA5; stim[1] = 8'h3C; stim[2] = 8'h00; stim[3] = 8'hFF; stim[4] = 8'h81;
        stim_n = 5;
        run_load(1'b0, 4, 3, "R5");
        chk(load_ok && !load_err, "R8", int'({load_ok, load_err}), 2);
        chk(trail == 3, "R8", trail, 3);
        chk(exp_q.size() == 0 && edges == 43, "R5", edges, 43);

        // R6 and R8: swapped words, done already high, no trailing pulse.
        for (int i = 0; i < 8; i++) stim[i] = 8'(8'h11 * (i + 1));
        stim_n = 8;
        run_load(1'b1, 2, 0, "R6");
        chk(load_ok, "R8", int'(load_ok), 1);
        chk(trail == 0 && exp_q.size() == 0, "R6", trail, 0);

        // R7: six bytes in swap mode, partial group dropped.
        stim_n = 6;
        run_load(1'b1, 1, -1, "R6");
        chk(load_err && err_code == 2'd3, "R7", int'(err_code), 3);
        chk(edges == 32 && exp_q.size() == 0, "R7", edges, 32);
        repeat (10) @(negedge clk);
        chk(load_err && err_code == 2'd3 && !busy, "R10", int'(err_code), 3);

        // R3: init never rises.
        stim_n = 2;
        run_load(1'b0, -1, -1, "R5");
        chk(load_err && err_code == 2'd1, "R3", int'(err_code), 1);
        chk(edges == 0, "R3", edges, 0);

        // R9: done never rises.
        stim[0] = 8'h5A; stim[1] = 8'hC3; stim_n = 2;
        run_load(1'b0, 3, -1, "R5");
        chk(load_err && err_code == 2'd2, "R9", int'(err_code), 2);
        chk(trail == DPUL, "R9", trail, DPUL);

        // R10: a fresh load after an error ends cleanly.
        stim[0] = 8'h96; stim_n = 1;
        run_load(1'b0, 0, 1, "R5");
        chk(load_ok && !load_err && err_code == 2'd0, "R10", int'(err_code), 0);
        chk(trail == 1, "R8", trail, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule